// File: doc/BRIEF.md
# Serial Controller Event Status and Interrupt Unit

This unit collects the event flags of a bus-master serial transfer engine into a 16-bit status word and turns them into one interrupt line and two DMA request lines. The engine raises flags with one-cycle set pulses and drops the ready flags with one-cycle clear pulses. Software reads and clears flags through a small register port with a strobe, a 4-bit word address and 16-bit data. It selects which flags raise the interrupt through an enable mask and hands the receive and transmit ready flags to a DMA engine through a buffer-control register.

A vector register gives a fast way to service interrupts. A read of it returns the 1-based position of the lowest flag that is both pending and enabled, and the same read clears that flag. A build parameter selects one of two register revisions. The newer revision has a 6-bit enable mask and a forced-event test write. The older one has a 5-bit mask and no test write.

Top module: `sei_unit`

## Requirements
- R1: After reset the status word, the enable mask and the DMA enables read as zero, and `irq_o`, `rx_dma_req_o` and `tx_dma_req_o` are low.
- R2: A bit of `evt_set_i` sets the matching status bit. A read at address 0x2 returns the status word, with bit 12 replaced by the live level of `bus_busy_i`. Status bit 12 itself is never stored.
- R3: `irq_o` is registered. In the cycle after the status word ANDed with the mask (address 0x1) becomes nonzero it is high, and in the cycle after that AND becomes zero it is low.
- R4: `rx_dma_req_o` follows status bit 3 (receive ready) while DMA bit 15 is set. `tx_dma_req_o` follows status bit 4 (transmit ready) while DMA bit 7 is set. Both are registered with one cycle of latency and are low while their enable is clear.
- R5: A write to address 0x5 keeps only bits 15 and 7, which read back in place. Writing bit 15 as one clears mask bit 3, and writing bit 7 as one clears mask bit 4.
- R6: A read of address 0x3 returns the 1-based index of the lowest set bit of status AND mask, or 0 if there is none. The read clears that one status bit.
- R7: A write to address 0x2 clears only those status bits that are set both in the written value and in 0x0027 (bits 0, 1, 2, 5). The ready bits 3 and 4 survive any such write.
- R8: A bit of `evt_clr_i` clears the matching status bit.
- R9: The mask keeps 6 bits in the newer revision (`REV` >= `NEW_REV_MIN`) and 5 bits in the older revision. Mask bits beyond that width read as zero.
- R10: A write to address 0xF with bit 11 set forces status bits 5..0 to one in the newer revision. In the older revision it has no effect.
- R11: When a set pulse and any clear source (status write, vector read, `evt_clr_i`) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (vector read side effect) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| evt_set_i | input | 16 | Per-bit status set pulses from the transfer engine |
| evt_clr_i | input | 16 | Per-bit status clear pulses from the transfer engine |
| bus_busy_i | input | 1 | Live bus-busy level shown in status bit 12 |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is a set pulse, a software clear and an engine clear all landing on one status bit in the same cycle. The bench drives the set vector, the clear vector and a status write in one cycle. It then reads the status word back to show that the set prevails and that untouched bits keep their value. The revision gate is covered by a second instance built with an older revision on the same stimulus, so the mask width and the forced-event write can be compared side by side.

// File: rtl/sei_pkg.sv
package sei_pkg;
  localparam int unsigned DW = 16;

  localparam logic [3:0] A_MASK = 4'h1;
  localparam logic [3:0] A_STAT = 4'h2;
  localparam logic [3:0] A_VEC  = 4'h3;
  localparam logic [3:0] A_DMA  = 4'h5;
  localparam logic [3:0] A_TEST = 4'hF;

  localparam int unsigned B_RX_RDY = 3;
  localparam int unsigned B_TX_RDY = 4;
  localparam int unsigned B_BUSY   = 12;
  localparam int unsigned B_DMA_RX = 15;
  localparam int unsigned B_DMA_TX = 7;
  localparam int unsigned B_FORCE  = 11;
  localparam int unsigned FORCE_W  = 6;

  localparam logic [DW-1:0] SW_CLR_MASK = 16'h0027;
  localparam logic [DW-1:0] STAT_KEEP   = 16'hEFFF;
endpackage

// File: rtl/sei_status_reg.sv
module sei_status_reg
  import sei_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         force_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] set_eff, force_vec, stat_d;

  assign set_eff   = set_i & STAT_KEEP[W-1:0];
  assign force_vec = force_i ? W'({FORCE_W{1'b1}}) : '0;
  // set beats clear
  assign stat_d    = (stat_o & ~clr_i) | set_eff | force_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= stat_d;
  end

  // R11: every pulsed bit is set afterwards
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_eff) |=> ((stat_o & $past(set_eff)) == $past(set_eff)));

  // R2: bus-busy position never stored
  a_r2_busy_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[B_BUSY]);
endmodule

// File: rtl/sei_vec_enc.sv
module sei_vec_enc #(
  parameter int unsigned W     = 16,
  localparam int unsigned IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        idx_o       = IDX_W'(k + 1);
        onehot_o    = '0;
        onehot_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sei_req_out.sv
module sei_req_out
  import sei_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pend_i,
  input  logic         rx_rdy_i,
  input  logic         tx_rdy_i,
  input  logic         rx_en_i,
  input  logic         tx_en_i,
  output logic         irq_o,
  output logic         rx_req_o,
  output logic         tx_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      rx_req_o <= 1'b0;
      tx_req_o <= 1'b0;
    end else begin
      irq_o    <= |pend_i;
      rx_req_o <= rx_en_i & rx_rdy_i;
      tx_req_o <= tx_en_i & tx_rdy_i;
    end
  end

  a_r3_irq_low_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> !irq_o);
  a_r4_rx_req_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_req_o);
  a_r4_tx_req_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tx_req_o);
endmodule

// File: rtl/sei_unit.sv
module sei_unit
  import sei_pkg::*;
#(
  parameter logic [7:0] REV         = 8'h3C,
  parameter logic [7:0] NEW_REV_MIN = 8'h34
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] evt_set_i,
  input  logic [DW-1:0] evt_clr_i,
  input  logic          bus_busy_i,
  output logic          irq_o,
  output logic          rx_dma_req_o,
  output logic          tx_dma_req_o
);
  localparam bit          IS_NEW = (REV >= NEW_REV_MIN);
  localparam int unsigned MASK_W = IS_NEW ? 6 : 5;
  localparam int unsigned IDX_W  = $clog2(DW + 1);

  logic              wr_mask, wr_stat, wr_dma, wr_test, rd_vec;
  logic [MASK_W-1:0] mask_q;
  logic              dma_rx_en_q, dma_tx_en_q;
  logic [DW-1:0]     stat, pend, onehot, clr_all, sw_clr, vec_clr;
  logic [IDX_W-1:0]  vec_idx;
  logic              force_evt;

  assign wr_mask = reg_wr_i && (reg_addr_i == A_MASK);
  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_dma  = reg_wr_i && (reg_addr_i == A_DMA);
  assign wr_test = reg_wr_i && (reg_addr_i == A_TEST);
  assign rd_vec  = reg_rd_i && (reg_addr_i == A_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      dma_rx_en_q <= 1'b0;
      dma_tx_en_q <= 1'b0;
    end else if (wr_mask) begin
      mask_q <= reg_wdata_i[MASK_W-1:0];
    end else if (wr_dma) begin
      dma_rx_en_q <= reg_wdata_i[B_DMA_RX];
      dma_tx_en_q <= reg_wdata_i[B_DMA_TX];
      if (reg_wdata_i[B_DMA_RX]) mask_q[B_RX_RDY] <= 1'b0;
      if (reg_wdata_i[B_DMA_TX]) mask_q[B_TX_RDY] <= 1'b0;
    end
  end

  assign pend      = stat & DW'(mask_q);
  assign sw_clr    = wr_stat ? (reg_wdata_i & SW_CLR_MASK) : '0;
  assign vec_clr   = rd_vec ? onehot : '0;
  assign clr_all   = sw_clr | vec_clr | evt_clr_i;
  assign force_evt = IS_NEW && wr_test && reg_wdata_i[B_FORCE];

  sei_status_reg #(.W(DW)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set_i),
    .clr_i   (clr_all),
    .force_i (force_evt),
    .stat_o  (stat)
  );

  sei_vec_enc #(.W(DW)) u_vec (
    .pend_i   (pend),
    .idx_o    (vec_idx),
    .onehot_o (onehot)
  );

  sei_req_out #(.W(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .rx_rdy_i (stat[B_RX_RDY]),
    .tx_rdy_i (stat[B_TX_RDY]),
    .rx_en_i  (dma_rx_en_q),
    .tx_en_i  (dma_tx_en_q),
    .irq_o    (irq_o),
    .rx_req_o (rx_dma_req_o),
    .tx_req_o (tx_dma_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_MASK: reg_rdata_o = DW'(mask_q);
      A_STAT: begin
        reg_rdata_o         = stat;
        reg_rdata_o[B_BUSY] = bus_busy_i;
      end
      A_VEC:  reg_rdata_o = DW'(vec_idx);
      A_DMA:  begin
        reg_rdata_o[B_DMA_RX] = dma_rx_en_q;
        reg_rdata_o[B_DMA_TX] = dma_tx_en_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  a_r5_rx_dma_drops_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dma && reg_wdata_i[B_DMA_RX]) |=> !mask_q[B_RX_RDY]);
  a_r5_tx_dma_drops_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dma && reg_wdata_i[B_DMA_TX]) |=> !mask_q[B_TX_RDY]);
  a_r6_vec_clears_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && (|onehot) && !(|(evt_set_i & onehot))) |=> ((stat & $past(onehot)) == '0));
  a_r7_rx_rdy_survives_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && stat[B_RX_RDY] && !evt_clr_i[B_RX_RDY] && !vec_clr[B_RX_RDY])
      |=> stat[B_RX_RDY]);
  a_r3_irq_high_on_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend) |=> irq_o);
endmodule

// File: tb/sei_unit_tb.sv
module sei_unit_tb_top;
  import sei_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0, busy = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0, set_v = '0, clr_v = '0;
  logic [DW-1:0] rdata, rdata_old;
  logic          irq, rxr, txr, irq_old, rxr_old, txr_old;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  sei_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_set_i(set_v), .evt_clr_i(clr_v),
    .bus_busy_i(busy), .irq_o(irq), .rx_dma_req_o(rxr), .tx_dma_req_o(txr));

  sei_unit #(.REV(8'h20)) dut_old_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_old), .evt_set_i(set_v), .evt_clr_i(clr_v),
    .bus_busy_i(busy), .irq_o(irq_old), .rx_dma_req_o(rxr_old), .tx_dma_req_o(txr_old));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] d, output logic [15:0] d_old);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata; d_old = rdata_old;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk); set_v = s; clr_v = c;
    @(negedge clk); set_v = '0; clr_v = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d, o;
    reg_rd(A_STAT, d, o); chk("R1 status", d, 16'h0); chk("R1 status old", o, 16'h0);
    reg_rd(A_MASK, d, o); chk("R1 mask", d, 16'h0);
    reg_rd(A_DMA, d, o);  chk("R1 dma", d, 16'h0);
    chk("R1 outputs", {13'b0, irq, rxr, txr}, 16'h0);
  endtask

  task automatic t_set_and_busy;
    logic [15:0] d, o;
    pulse(16'h1C06, 16'h0);
    reg_rd(A_STAT, d, o); chk("R2 status set", d, 16'h0C06);
    busy = 1'b1;
    reg_rd(A_STAT, d, o); chk("R2 busy shown", d, 16'h1C06);
    busy = 1'b0;
  endtask

  task automatic t_irq;
    chk("R3 irq masked", {15'b0, irq}, 16'h0);
    reg_wr(A_MASK, 16'h0004);
    chk("R3 irq latency", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R3 irq high", {15'b0, irq}, 16'h1);
  endtask

  task automatic t_sw_clear;
    logic [15:0] d, o;
    pulse(16'h0018, 16'h0);
    reg_wr(A_STAT, 16'hFFFF);
    reg_rd(A_STAT, d, o); chk("R7 w1c only 0x27", d, 16'h0C18);
    chk("R3 irq low", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_hw_clear;
    logic [15:0] d, o;
    pulse(16'h0, 16'h0018);
    reg_rd(A_STAT, d, o); chk("R8 hw clear", d, 16'h0C00);
    pulse(16'h0, 16'h0C00);
  endtask

  task automatic t_vector;
    logic [15:0] d, o;
    pulse(16'h0024, 16'h0);
    reg_wr(A_MASK, 16'h003F);
    reg_rd(A_VEC, d, o); chk("R6 vec lowest", d, 16'd3);
    reg_rd(A_STAT, d, o); chk("R6 vec cleared", d, 16'h0020);
    reg_rd(A_VEC, d, o); chk("R6 vec next", d, 16'd6);
    reg_rd(A_VEC, d, o); chk("R6 vec none", d, 16'd0);
    reg_rd(A_STAT, d, o); chk("R6 all clear", d, 16'h0);
  endtask

  task automatic t_mask_width;
    logic [15:0] d, o;
    reg_wr(A_MASK, 16'hFFFF);
    reg_rd(A_MASK, d, o);
    chk("R9 mask new", d, 16'h003F);
    chk("R9 mask old", o, 16'h001F);
  endtask

  task automatic t_dma_reg;
    logic [15:0] d, o;
    reg_wr(A_DMA, 16'hFFFF);
    reg_rd(A_DMA, d, o);  chk("R5 dma keep", d, 16'h8080);
    reg_rd(A_MASK, d, o); chk("R5 ie dropped", d, 16'h0027);
  endtask

  task automatic t_dma_req;
    pulse(16'h0008, 16'h0);
    @(negedge clk);
    chk("R4 rx req", {14'b0, rxr, txr}, 16'h2);
    pulse(16'h0010, 16'h0);
    @(negedge clk);
    chk("R4 tx req", {14'b0, rxr, txr}, 16'h3);
    chk("R3 ready not enabled", {15'b0, irq}, 16'h0);
    reg_wr(A_DMA, 16'h0000);
    @(negedge clk);
    chk("R4 req off", {14'b0, rxr, txr}, 16'h0);
  endtask

  task automatic t_set_wins;
    logic [15:0] d, o;
    @(negedge clk);
    set_v = 16'h000A; clr_v = 16'h0008; wr = 1'b1; addr = A_STAT; wdata = 16'h0002;
    @(negedge clk);
    set_v = '0; clr_v = '0; wr = 1'b0; wdata = '0;
    reg_rd(A_STAT, d, o); chk("R11 set wins", d, 16'h001A);
  endtask

  task automatic t_force;
    logic [15:0] d, o;
    pulse(16'h0, 16'hFFFF);
    reg_wr(A_TEST, 16'h0800);
    reg_rd(A_STAT, d, o);
    chk("R10 force new", d, 16'h003F);
    chk("R10 force old ignored", o, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_and_busy();
    t_irq();
    t_sw_clear();
    t_hw_clear();
    t_vector();
    t_mask_width();
    t_dma_reg();
    t_dma_req();
    t_set_wins();
    t_force();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule